// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Comparator Unit

This block sits beside a processor core and compares the core's instruction stream and data-memory traffic against a small bank of programmable debug comparators. Breakpoint comparators look at the address of the instruction about to execute. Watchpoint comparators look at the byte address of each load or store. Each watchpoint has its own access-kind mode: off, loads only, stores only, or both.

A watchpoint hit drives a stall line in the same cycle as the access. The core uses it to hold back the access before memory is changed. One cycle later the unit raises a watchpoint exception request, and only if the comparator that hit is still armed. Breakpoint matches raise a separate breakpoint request one cycle after the fetch. When both kinds of request would appear together, the watchpoint request wins. The breakpoint is found again when the instruction is fetched a second time.

Comparators are set through a single-cycle write port that selects the comparator kind and index, the address and the mode. A new setting applies from the cycle after the write. Disarming a comparator also discards a request it raised in the cycle of the write.

Top module: `dbg_trigger_unit`

## Requirements
- R1: After reset every breakpoint is disarmed, every watchpoint mode is off (0), and `stall_access`, `wp_req` and `bp_req` are low.
- R2: Watchpoint mode encoding: 0 = off, 1 = loads only, 2 = stores only, 3 = loads and stores. A watchpoint in mode 0 never hits, whatever its address register holds. A mode-1 watchpoint ignores stores and a mode-2 watchpoint ignores loads.
- R3: `stall_access` is high in the same cycle as a load or store whose address exactly equals the address of an armed watchpoint whose mode accepts that access kind. An address one byte away does not hit.
- R4: `wp_req` is high in the cycle after a cycle in which `stall_access` was high, and is low otherwise. This holds provided the hitting watchpoint is still armed in that later cycle.
- R5: `bp_req` is high in the cycle after a cycle in which `pc_valid` was high and `pc` equalled the address of an armed breakpoint. A breakpoint is armed when bit 0 of `cfg_mode` was 1 at its last write. With `pc_valid` low, no breakpoint fires.
- R6: When a breakpoint and a watchpoint hit in the same cycle, only `wp_req` is raised in the following cycle; `bp_req` and `wp_req` are never high together.
- R7: A configuration write (`cfg_we` high, `cfg_wp` = 1 for a watchpoint or 0 for a breakpoint, `cfg_idx` the comparator index) takes effect from the next cycle. A write whose index is not below the comparator count of its kind is ignored.
- R8: Disarming a comparator in the same cycle as its hit leaves that cycle's stall unchanged, but drops the request it would have raised in the next cycle.
- R9: Every comparator of a kind is checked in parallel; a hit by any one of them produces the stall or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wp | input | 1 | 1 selects a watchpoint, 0 a breakpoint |
| cfg_idx | input | 2 | Comparator index |
| cfg_addr | input | 32 | Comparator address |
| cfg_mode | input | 2 | Watchpoint mode; bit 0 is the breakpoint arm bit |
| pc | input | 32 | Address of the instruction about to execute |
| pc_valid | input | 1 | Instruction valid strobe |
| dacc_addr | input | 32 | Data access byte address |
| dacc_rd | input | 1 | Data load strobe |
| dacc_wr | input | 1 | Data store strobe |
| stall_access | output | 1 | Hold the current data access (watchpoint hit) |
| bp_req | output | 1 | Breakpoint exception request |
| wp_req | output | 1 | Watchpoint exception request |

## Verification
The bench goes after the access-kind filter. A design that ignored the mode would stall stores on a load-only watchpoint, or stall on a comparator that is off. It checks byte-exact matching: an address one byte off must not hit, and a design comparing at word granularity would stall there. It checks a write that arms a breakpoint in the same cycle as a matching fetch, and a write that disarms a watchpoint in the same cycle as its hit. A design applying the write too early would fire or miss there, and one that kept the pending hit would raise a request that should have been dropped. It checks a simultaneous breakpoint and watchpoint hit, where a wrong priority shows up as `bp_req` high.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    localparam int DBG_AW  = 32;
    localparam int IDX_W   = 2;
    localparam int MAX_CMP = 4;

    typedef enum logic [1:0] {
        WP_OFF   = 2'b00,
        WP_READ  = 2'b01,
        WP_WRITE = 2'b10,
        WP_BOTH  = 2'b11
    } wp_mode_e;

    typedef struct packed {
        logic [DBG_AW-1:0] addr;
        logic              en;
    } bp_cfg_t;

    typedef struct packed {
        logic [DBG_AW-1:0] addr;
        wp_mode_e          mode;
    } wp_cfg_t;

    function automatic logic kind_hit(wp_mode_e m, logic rd, logic wr);
        return (rd && (m == WP_READ  || m == WP_BOTH)) ||
               (wr && (m == WP_WRITE || m == WP_BOTH));
    endfunction

    function automatic logic wp_armed(wp_mode_e m);
        return m != WP_OFF;
    endfunction
endpackage

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs
    import dbg_pkg::*;
#(
    parameter int NUM_BP = 2,
    parameter int NUM_WP = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic                         cfg_wp,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic [DBG_AW-1:0]            cfg_addr,
    input  logic [1:0]                   cfg_mode,
    output bp_cfg_t [NUM_BP-1:0]         bp_cfg,
    output wp_cfg_t [NUM_WP-1:0]         wp_cfg
);
    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        always_ff @(posedge clk) begin
            if (rst) begin
                bp_cfg[i] <= '0;
            end else if (cfg_we && !cfg_wp && cfg_idx == IDX_W'(i)) begin
                bp_cfg[i].addr <= cfg_addr;
                bp_cfg[i].en   <= cfg_mode[0];
            end
        end
    end

    for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
        always_ff @(posedge clk) begin
            if (rst) begin
                wp_cfg[j].addr <= '0;
                wp_cfg[j].mode <= WP_OFF;
            end else if (cfg_we && cfg_wp && cfg_idx == IDX_W'(j)) begin
                wp_cfg[j].addr <= cfg_addr;
                wp_cfg[j].mode <= wp_mode_e'(cfg_mode);
            end
        end
    end
endmodule

// File: rtl/dbg_bp_match.sv
module dbg_bp_match
    import dbg_pkg::*;
#(
    parameter int NUM_BP = 2
) (
    input  bp_cfg_t [NUM_BP-1:0] bp_cfg,
    input  logic [DBG_AW-1:0]    pc,
    input  logic                 pc_valid,
    output logic [NUM_BP-1:0]    bp_hit,
    output logic [NUM_BP-1:0]    bp_en
);
    for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
        assign bp_en[i]  = bp_cfg[i].en;
        assign bp_hit[i] = pc_valid && bp_cfg[i].en && (pc == bp_cfg[i].addr);
    end
endmodule

// File: rtl/dbg_wp_match.sv
module dbg_wp_match
    import dbg_pkg::*;
#(
    parameter int NUM_WP = 4
) (
    input  wp_cfg_t [NUM_WP-1:0] wp_cfg,
    input  logic [DBG_AW-1:0]    dacc_addr,
    input  logic                 dacc_rd,
    input  logic                 dacc_wr,
    output logic [NUM_WP-1:0]    wp_hit,
    output logic [NUM_WP-1:0]    wp_en
);
    for (genvar j = 0; j < NUM_WP; j++) begin : g_cmp
        assign wp_en[j]  = wp_armed(wp_cfg[j].mode);
        assign wp_hit[j] = kind_hit(wp_cfg[j].mode, dacc_rd, dacc_wr) &&
                           (dacc_addr == wp_cfg[j].addr);
    end
endmodule

// File: rtl/dbg_trigger_unit.sv
module dbg_trigger_unit
    import dbg_pkg::*;
#(
    parameter int NUM_BP = 2,
    parameter int NUM_WP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_wp,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DBG_AW-1:0] cfg_addr,
    input  logic [1:0]        cfg_mode,
    input  logic [DBG_AW-1:0] pc,
    input  logic              pc_valid,
    input  logic [DBG_AW-1:0] dacc_addr,
    input  logic              dacc_rd,
    input  logic              dacc_wr,
    output logic              stall_access,
    output logic              bp_req,
    output logic              wp_req
);
    bp_cfg_t [NUM_BP-1:0] bp_cfg;
    wp_cfg_t [NUM_WP-1:0] wp_cfg;
    logic [NUM_BP-1:0]    bp_hit, bp_en, bp_hit_q;
    logic [NUM_WP-1:0]    wp_hit, wp_en, wp_hit_q;

    dbg_cfg_regs #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wp(cfg_wp),
        .cfg_idx(cfg_idx), .cfg_addr(cfg_addr), .cfg_mode(cfg_mode),
        .bp_cfg(bp_cfg), .wp_cfg(wp_cfg)
    );

    dbg_bp_match #(.NUM_BP(NUM_BP)) u_bp (
        .bp_cfg(bp_cfg), .pc(pc), .pc_valid(pc_valid),
        .bp_hit(bp_hit), .bp_en(bp_en)
    );

    dbg_wp_match #(.NUM_WP(NUM_WP)) u_wp (
        .wp_cfg(wp_cfg), .dacc_addr(dacc_addr), .dacc_rd(dacc_rd),
        .dacc_wr(dacc_wr), .wp_hit(wp_hit), .wp_en(wp_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bp_hit_q <= '0;
            wp_hit_q <= '0;
        end else begin
            bp_hit_q <= bp_hit;
            wp_hit_q <= wp_hit;
        end
    end

    assign stall_access = |wp_hit;
    assign wp_req       = |(wp_hit_q & wp_en);
    assign bp_req       = (|(bp_hit_q & bp_en)) && !wp_req;
endmodule

// File: rtl/dbg_trigger_chk.sv
module dbg_trigger_chk (
    input logic clk,
    input logic rst,
    input logic pc_valid,
    input logic dacc_rd,
    input logic dacc_wr,
    input logic stall_access,
    input logic bp_req,
    input logic wp_req
);
    assert_stall_needs_access_R3: assert property (@(posedge clk) disable iff (rst)
        stall_access |-> (dacc_rd || dacc_wr));

    assert_wp_after_stall_R4: assert property (@(posedge clk) disable iff (rst)
        wp_req |-> $past(stall_access));

    assert_bp_after_fetch_R5: assert property (@(posedge clk) disable iff (rst)
        bp_req |-> $past(pc_valid));

    assert_wp_priority_R6: assert property (@(posedge clk) disable iff (rst)
        !(bp_req && wp_req));
endmodule

bind dbg_trigger_unit dbg_trigger_chk u_chk (
    .clk(clk), .rst(rst), .pc_valid(pc_valid), .dacc_rd(dacc_rd),
    .dacc_wr(dacc_wr), .stall_access(stall_access), .bp_req(bp_req),
    .wp_req(wp_req)
);

// File: tb/test_dbg_trigger_unit.sv
module test_dbg_trigger_unit;
    localparam int NBP = 2;
    localparam int NWP = 4;

    logic        clk = 0;
    logic        rst = 1;
    logic        cfg_we = 0, cfg_wp = 0;
    logic [1:0]  cfg_idx = 0, cfg_mode = 0;
    logic [31:0] cfg_addr = 0, pc = 0, dacc_addr = 0;
    logic        pc_valid = 0, dacc_rd = 0, dacc_wr = 0;
    logic        stall_access, bp_req, wp_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dbg_trigger_unit #(.NUM_BP(NBP), .NUM_WP(NWP)) i_dbg_trigger_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wp(cfg_wp),
        .cfg_idx(cfg_idx), .cfg_addr(cfg_addr), .cfg_mode(cfg_mode),
        .pc(pc), .pc_valid(pc_valid), .dacc_addr(dacc_addr),
        .dacc_rd(dacc_rd), .dacc_wr(dacc_wr),
        .stall_access(stall_access), .bp_req(bp_req), .wp_req(wp_req)
    );

    // behavioural reference
    logic [31:0] m_baddr [NBP];
    bit          m_ben   [NBP];
    logic [31:0] m_waddr [NWP];
    int          m_wmode [NWP];
    bit          p_bp    [NBP];
    bit          p_wp    [NWP];

    function automatic bit m_wp_hit(int j);
        bit kind;
        kind = (dacc_rd && (m_wmode[j] == 1 || m_wmode[j] == 3)) ||
               (dacc_wr && (m_wmode[j] == 2 || m_wmode[j] == 3));
        return kind && dacc_addr == m_waddr[j];
    endfunction

    function automatic bit exp_stall();
        bit s = 0;
        for (int j = 0; j < NWP; j++) s |= m_wp_hit(j);
        return s;
    endfunction

    function automatic bit exp_wp();
        bit r = 0;
        for (int j = 0; j < NWP; j++) r |= p_wp[j] && m_wmode[j] != 0;
        return r;
    endfunction

    function automatic bit exp_bp();
        bit r = 0;
        for (int i = 0; i < NBP; i++) r |= p_bp[i] && m_ben[i];
        return r && !exp_wp();
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBP; i++) begin m_baddr[i] = 0; m_ben[i] = 0; p_bp[i] = 0; end
            for (int j = 0; j < NWP; j++) begin m_waddr[j] = 0; m_wmode[j] = 0; p_wp[j] = 0; end
        end else begin
            for (int i = 0; i < NBP; i++)
                p_bp[i] = pc_valid && m_ben[i] && pc == m_baddr[i];
            for (int j = 0; j < NWP; j++) p_wp[j] = m_wp_hit(j);
            if (cfg_we) begin
                if (cfg_wp && int'(cfg_idx) < NWP) begin
                    m_waddr[cfg_idx] = cfg_addr; m_wmode[cfg_idx] = int'(cfg_mode);
                end else if (!cfg_wp && int'(cfg_idx) < NBP) begin
                    m_baddr[cfg_idx] = cfg_addr; m_ben[cfg_idx] = cfg_mode[0];
                end
            end
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 stall_access model", stall_access, exp_stall());
            chk("R4 wp_req model", wp_req, exp_wp());
            chk("R5 bp_req model", bp_req, exp_bp());
        end
    end

    task automatic drive(bit we, bit wsel, int idx, logic [31:0] ca, int md,
                         bit pv, logic [31:0] p, bit rd, bit wr, logic [31:0] da);
        @(posedge clk); #1;
        cfg_we = we; cfg_wp = wsel; cfg_idx = 2'(idx); cfg_addr = ca; cfg_mode = 2'(md);
        pc_valid = pv; pc = p; dacc_rd = rd; dacc_wr = wr; dacc_addr = da;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic setcfg(bit wsel, int idx, logic [31:0] ca, int md);
        drive(1, wsel, idx, ca, md, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R1 stall after reset", stall_access, 0);
        chk("R1 wp_req after reset", wp_req, 0);
        chk("R1 bp_req after reset", bp_req, 0);
        // R1: watchpoints off after reset, even at address 0
        drive(0, 0, 0, 0, 0, 1, 0, 1, 1, 0);
        @(negedge clk); chk("R1 no hit at reset address", stall_access, 0);

        setcfg(1, 0, 32'h100, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 32'h100);
        @(negedge clk); chk("R3 load hit stalls", stall_access, 1);
        idle();
        @(negedge clk); chk("R4 wp_req follows", wp_req, 1);
        idle();
        @(negedge clk); chk("R4 wp_req single pulse", wp_req, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h100);
        @(negedge clk); chk("R2 read-only ignores store", stall_access, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 32'h101);
        @(negedge clk); chk("R3 byte exact miss", stall_access, 0);

        setcfg(1, 1, 32'h200, 2);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h200);
        @(negedge clk); chk("R9 second watchpoint store hit", stall_access, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 32'h200);
        @(negedge clk); chk("R2 write-only ignores load", stall_access, 0);

        setcfg(1, 2, 32'h300, 3);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 32'h300);
        @(negedge clk); chk("R2 both-mode load", stall_access, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h300);
        @(negedge clk); chk("R2 both-mode store", stall_access, 1);

        setcfg(1, 3, 32'h400, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 1, 32'h400);
        @(negedge clk); chk("R2 mode off never hits", stall_access, 0);

        setcfg(0, 0, 32'h1000, 1);
        drive(0, 0, 0, 0, 0, 1, 32'h1000, 0, 0, 0);
        idle();
        @(negedge clk); chk("R5 breakpoint fires", bp_req, 1);
        drive(0, 0, 0, 0, 0, 0, 32'h1000, 0, 0, 0);
        idle();
        @(negedge clk); chk("R5 no fire without pc_valid", bp_req, 0);

        drive(0, 0, 0, 0, 0, 1, 32'h1000, 1, 0, 32'h100);
        idle();
        @(negedge clk);
        chk("R6 watchpoint reported", wp_req, 1);
        chk("R6 breakpoint suppressed", bp_req, 0);

        drive(1, 0, 1, 32'h2000, 1, 1, 32'h2000, 0, 0, 0);
        idle();
        @(negedge clk); chk("R7 write applies next cycle", bp_req, 0);
        drive(0, 0, 0, 0, 0, 1, 32'h2000, 0, 0, 0);
        idle();
        @(negedge clk); chk("R7 new breakpoint fires", bp_req, 1);
        setcfg(0, 3, 32'h3000, 1);
        drive(0, 0, 0, 0, 0, 1, 32'h3000, 0, 0, 0);
        idle();
        @(negedge clk); chk("R7 out-of-range index ignored", bp_req, 0);

        drive(1, 1, 0, 32'h100, 0, 0, 0, 1, 0, 32'h100);
        @(negedge clk); chk("R8 stall still in clear cycle", stall_access, 1);
        idle();
        @(negedge clk); chk("R8 wp request dropped", wp_req, 0);
        drive(1, 0, 0, 32'h1000, 0, 1, 32'h1000, 0, 0, 0);
        idle();
        @(negedge clk); chk("R8 bp request dropped", bp_req, 0);

        for (int n = 0; n < 600; n++) begin
            logic [31:0] pool [5];
            pool = '{32'h100, 32'h101, 32'h200, 32'h300, 32'h1000};
            drive(($urandom % 4) == 0, $urandom % 2, $urandom % 4,
                  pool[$urandom % 5], $urandom % 4,
                  $urandom % 2, pool[$urandom % 5],
                  $urandom % 2, $urandom % 2, pool[$urandom % 5]);
        end
        idle();
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule